// File: doc/BRIEF.md
# Debug Trigger Match Unit

This block holds four hardware breakpoint and watchpoint comparators for a processor debug module. Every cycle it is shown one access: its kind (instruction fetch, store or load), the privilege level of the hart, the address, the data value, the current debug cause code and a flag that selects 32-bit operand width. Each trigger compares either the address or the data against its own compare register. It can use one of six modes: equality, unsigned greater-or-equal, unsigned less-than, a naturally aligned power-of-two range coded by trailing ones, and two compares masked by the upper half of the compare register. A trigger only takes part when the access kind and the privilege level are both enabled in its control word. Triggers can be chained so that a group reports only when all of its members match.

Software or a debug transport writes the control and compare registers through a single write port. The unit reports a per-trigger raw match vector, a combinational hit flag with the index of the reported trigger, and a registered copy of that hit and index. A four-bit action code is stored with each trigger but does not change matching.

The chain walk is a small state machine that is unrolled across the triggers in ascending order within one cycle. It has two states. SCAN_OPEN means triggers are being evaluated. SCAN_SKIP means a chained group has failed and its remaining members are being passed over. The walk goes from SCAN_OPEN to SCAN_SKIP when a trigger with chain set does not qualify. It goes from SCAN_SKIP back to SCAN_OPEN at the first trigger with chain clear, and that trigger is itself passed over. It stays in SCAN_OPEN when a trigger qualifies with chain set, or when a trigger with chain clear does not qualify. The walk ends at the first trigger that qualifies with chain clear while in SCAN_OPEN, and that trigger is reported.

Top module: `trig_match_unit`

## Requirements
- R1: After reset all control and compare registers are zero, so no trigger qualifies for any access, and `hit_q`/`hit_idx_q` read 0 during and after reset until an access fires.
- R2: When several triggers would report, the lowest index wins, and `hit_idx` carries that index.
- R3: While `dbg_cause` is nonzero, `raw_hit` is all zero and `hit` is 0 whatever the access.
- R4: A trigger qualifies only when the enable bit for the access kind is set (`acc_op` 0 = fetch uses bit 2, 1 = store uses bit 1, 2 = load uses bit 0, 3 = no access never qualifies). The enable bit for the privilege must also be set (`acc_priv` 0 = U uses bit 3, 1 = S uses bit 4, 3 = M uses bit 5, 2 never qualifies).
- R5: Control bit 6 set makes `acc_data` the compare operand, and clear makes it `acc_addr`.
- R6: With `acc_narrow` high, bits 63:32 of the operand are cleared before the compare, and the half-width used by the masked modes becomes 16 instead of 32.
- R7: Mode field bits 9:7: 0 fires on operand equal to the compare value, 2 fires on operand >= compare value and 3 fires on operand < compare value, all unsigned.
- R8: Mode 1 counts the run of ones from bit 0 of the compare value, clears that many low bits to form a mask, and fires when operand and compare value agree under the mask. An all-ones compare value matches everything.
- R9: Mode 4 fires when (operand & M) == (cmp & M) with M = cmp shifted right by the half-width. Mode 5 does the same with the operand shifted right by the half-width first. Modes 6 and 7 never fire.
- R10: A qualifying trigger with chain bit 10 set does not report. The first later qualifying trigger with chain clear reports its own index.
- R11: A trigger with chain set that does not qualify causes every following trigger, up to and including the next one with chain clear, to be passed over. Evaluation then resumes.
- R12: `hit_q` and `hit_idx_q` equal `hit` and `hit_idx` from the previous cycle.
- R13: With `cfg_we` high, `cfg_sel` 0 writes `cfg_wdata[14:0]` to the control word of trigger `cfg_idx`, and `cfg_sel` 1 writes all 64 bits to its compare register, taking effect from the next cycle. The action code in bits 14:11 is stored but has no effect on matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 2 | Trigger selected for the write |
| cfg_sel | input | 1 | 0 = control word, 1 = compare register |
| cfg_wdata | input | 64 | Write data |
| acc_op | input | 2 | Access kind: 0 fetch, 1 store, 2 load, 3 none |
| acc_priv | input | 2 | Privilege: 0 U, 1 S, 3 M |
| acc_narrow | input | 1 | 32-bit operand width |
| acc_addr | input | 64 | Access address |
| acc_data | input | 64 | Access data value |
| dbg_cause | input | 3 | Debug cause code; nonzero means halted |
| raw_hit | output | 4 | Per-trigger qualification before chaining |
| hit | output | 1 | A trigger reports this cycle |
| hit_idx | output | 2 | Index of the reported trigger |
| hit_q | output | 1 | Registered `hit` |
| hit_idx_q | output | 2 | Registered `hit_idx` |

## Verification
A corrupted control word or compare register appears at the ports in the very next access that touches that trigger. It shows as a wrong bit in `raw_hit` in the same cycle, and as a wrong `hit_q` one clock later. A fault in the chain walk cannot be seen in `raw_hit`. It shows only in `hit`/`hit_idx` when a chained group is split or wrongly skipped, so the bench builds groups that pass, groups that fail with a later free trigger, and groups that are cut short by halting. Because the reference model is compared every clock, a divergence is reported in the cycle it first reaches an output.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
package trig_pkg;

    typedef enum logic [1:0] {
        OP_EXEC  = 2'd0,
        OP_STORE = 2'd1,
        OP_LOAD  = 2'd2,
        OP_NONE  = 2'd3
    } acc_op_e;

    typedef enum logic [1:0] {
        PL_USER  = 2'd0,
        PL_SUPER = 2'd1,
        PL_RSVD  = 2'd2,
        PL_MACH  = 2'd3
    } priv_e;

    typedef enum logic [2:0] {
        CM_EQ    = 3'd0,
        CM_NAPOT = 3'd1,
        CM_GE    = 3'd2,
        CM_LT    = 3'd3,
        CM_MLO   = 3'd4,
        CM_MHI   = 3'd5,
        CM_RSV6  = 3'd6,
        CM_RSV7  = 3'd7
    } cmp_mode_e;

    // Fields the comparator needs (bits 9:0 of the control word)
    typedef struct packed {
        cmp_mode_e mode;      // 9:7
        logic      use_data;  // 6
        logic      en_m;      // 5
        logic      en_s;      // 4
        logic      en_u;      // 3
        logic      en_exec;   // 2
        logic      en_store;  // 1
        logic      en_load;   // 0
    } trig_match_cfg_t;

    typedef struct packed {
        logic [3:0]      act;    // 14:11, kept only
        logic            chain;  // 10
        trig_match_cfg_t m;      // 9:0
    } trig_ctrl_t;

    localparam int CTRL_W = $bits(trig_ctrl_t);

    typedef enum logic {
        SCAN_OPEN = 1'b0,
        SCAN_SKIP = 1'b1
    } scan_st_e;

endpackage

// File: rtl/trig_cmp.sv
`timescale 1ns/1ps
module trig_cmp
    import trig_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  trig_match_cfg_t   cfg,
    input  logic [REG_W-1:0]  cmp_val,
    input  logic [1:0]        op,
    input  logic [1:0]        priv,
    input  logic              narrow,
    input  logic [REG_W-1:0]  addr,
    input  logic [REG_W-1:0]  data,
    output logic              qual
);
    localparam int NARROW_W    = REG_W / 2;
    localparam int HALF_FULL   = REG_W / 2;
    localparam int HALF_NARROW = NARROW_W / 2;
    localparam logic [REG_W-1:0] ONE = {{(REG_W-1){1'b0}}, 1'b1};
    localparam logic [REG_W-1:0] LOW_KEEP = {{(REG_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic             op_ok;
    logic             priv_ok;
    logic             cmp_ok;
    logic [REG_W-1:0] operand;
    logic [REG_W-1:0] low_ones;
    logic [REG_W-1:0] napot_mask;
    logic [REG_W-1:0] half_mask;
    logic [REG_W-1:0] upper_part;

    always_comb begin
        unique case (acc_op_e'(op))
            OP_EXEC:  op_ok = cfg.en_exec;
            OP_STORE: op_ok = cfg.en_store;
            OP_LOAD:  op_ok = cfg.en_load;
            OP_NONE:  op_ok = 1'b0;
        endcase
    end

    always_comb begin
        unique case (priv_e'(priv))
            PL_USER:  priv_ok = cfg.en_u;
            PL_SUPER: priv_ok = cfg.en_s;
            PL_MACH:  priv_ok = cfg.en_m;
            PL_RSVD:  priv_ok = 1'b0;
        endcase
    end

    always_comb begin
        operand = cfg.use_data ? data : addr;
        if (narrow) begin
            operand = operand & LOW_KEEP;
        end
        // run of ones from bit 0, isolated without a counter
        low_ones   = cmp_val & ~(cmp_val + ONE);
        napot_mask = ~low_ones;
        half_mask  = narrow ? (cmp_val >> HALF_NARROW) : (cmp_val >> HALF_FULL);
        upper_part = narrow ? (operand >> HALF_NARROW) : (operand >> HALF_FULL);
    end

    always_comb begin
        unique case (cfg.mode)
            CM_EQ:    cmp_ok = (operand == cmp_val);
            CM_NAPOT: cmp_ok = ((operand & napot_mask) == (cmp_val & napot_mask));
            CM_GE:    cmp_ok = (operand >= cmp_val);
            CM_LT:    cmp_ok = (operand < cmp_val);
            CM_MLO:   cmp_ok = ((operand & half_mask) == (cmp_val & half_mask));
            CM_MHI:   cmp_ok = ((upper_part & half_mask) == (cmp_val & half_mask));
            CM_RSV6,
            CM_RSV7:  cmp_ok = 1'b0;
        endcase
    end

    assign qual = op_ok & priv_ok & cmp_ok;

endmodule

// File: rtl/trig_scan.sv
`timescale 1ns/1ps
module trig_scan
    import trig_pkg::*;
#(
    parameter int N_TRIG = 4,
    localparam int IDX_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
    input  logic [N_TRIG-1:0] qual,
    input  logic [N_TRIG-1:0] chain,
    input  logic              halted,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);
    scan_st_e st;
    logic     found;

    always_comb begin
        st      = SCAN_OPEN;
        found   = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < N_TRIG; i++) begin
            if (!found && !halted) begin
                unique case (st)
                    SCAN_OPEN: begin
                        if (qual[i]) begin
                            if (!chain[i]) begin
                                found   = 1'b1;
                                hit_idx = IDX_W'(i);
                            end
                        end else if (chain[i]) begin
                            st = SCAN_SKIP;
                        end
                    end
                    SCAN_SKIP: begin
                        if (!chain[i]) begin
                            st = SCAN_OPEN;
                        end
                    end
                endcase
            end
        end
        hit = found;
    end

endmodule

// File: rtl/trig_match_unit.sv
`timescale 1ns/1ps
module trig_match_unit
    import trig_pkg::*;
#(
    parameter int REG_W  = 64,
    parameter int N_TRIG = 4,
    parameter int CAUSE_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [$clog2(N_TRIG)-1:0]   cfg_idx,
    input  logic                        cfg_sel,
    input  logic [REG_W-1:0]            cfg_wdata,
    input  logic [1:0]                  acc_op,
    input  logic [1:0]                  acc_priv,
    input  logic                        acc_narrow,
    input  logic [REG_W-1:0]            acc_addr,
    input  logic [REG_W-1:0]            acc_data,
    input  logic [CAUSE_W-1:0]          dbg_cause,
    output logic [N_TRIG-1:0]           raw_hit,
    output logic                        hit,
    output logic [$clog2(N_TRIG)-1:0]   hit_idx,
    output logic                        hit_q,
    output logic [$clog2(N_TRIG)-1:0]   hit_idx_q
);
    localparam int IDX_W = $clog2(N_TRIG);

    trig_ctrl_t         ctrl_q [N_TRIG];
    logic [REG_W-1:0]   cmp_q  [N_TRIG];
    logic [N_TRIG-1:0]  qual;
    logic [N_TRIG-1:0]  chain_vec;
    logic               halted;

    assign halted = (dbg_cause != '0);

    // register bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_TRIG; i++) begin
                ctrl_q[i] <= '0;
                cmp_q[i]  <= '0;
            end
        end else if (cfg_we) begin
            if (cfg_sel) begin
                cmp_q[cfg_idx] <= cfg_wdata;
            end else begin
                ctrl_q[cfg_idx] <= trig_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            end
        end
    end

    generate
        for (genvar g = 0; g < N_TRIG; g++) begin : g_trig
            trig_cmp #(.REG_W(REG_W)) i_cmp (
                .cfg     (ctrl_q[g].m),
                .cmp_val (cmp_q[g]),
                .op      (acc_op),
                .priv    (acc_priv),
                .narrow  (acc_narrow),
                .addr    (acc_addr),
                .data    (acc_data),
                .qual    (qual[g])
            );
            assign chain_vec[g] = ctrl_q[g].chain;
        end
    endgenerate

    assign raw_hit = halted ? '0 : qual;

    trig_scan #(.N_TRIG(N_TRIG)) i_scan (
        .qual    (qual),
        .chain   (chain_vec),
        .halted  (halted),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    // registered result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q     <= 1'b0;
            hit_idx_q <= '0;
        end else begin
            hit_q     <= hit;
            hit_idx_q <= hit ? hit_idx : '0;
        end
    end

    // R3
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_cause != '0) |-> (!hit && raw_hit == '0));

    // R10
    report_unchained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (raw_hit[hit_idx] && !chain_vec[hit_idx]));

    // R12
    hit_reg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (hit_q && hit_idx_q == $past(hit_idx)));

    // R12
    miss_reg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !hit_q);

    // R4
    no_access_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_op == 2'd3) |-> (raw_hit == '0 && !hit));

    // R13
    act_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel) |=>
            (ctrl_q[$past(cfg_idx)].act == $past(cfg_wdata[CTRL_W-1:CTRL_W-4])));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!hit_q && hit_idx_q == '0));

endmodule

// File: tb/test_trig_match_unit.sv
`timescale 1ns/1ps
module test_trig_match_unit;
    localparam int W = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_idx = '0;
    logic          cfg_sel = 1'b0;
    logic [W-1:0]  cfg_wdata = '0;
    logic [1:0]    acc_op = 2'd3;
    logic [1:0]    acc_priv = 2'd3;
    logic          acc_narrow = 1'b0;
    logic [W-1:0]  acc_addr = '0;
    logic [W-1:0]  acc_data = '0;
    logic [2:0]    dbg_cause = '0;
    logic [3:0]    raw_hit;
    logic          hit;
    logic [1:0]    hit_idx;
    logic          hit_q;
    logic [1:0]    hit_idx_q;

    int n_chk = 0;
    int n_err = 0;
    bit [14:0] m_ctrl [4];
    bit [63:0] m_cmp  [4];
    bit [63:0] pool   [8];

    always #10 clk = ~clk;

    trig_match_unit i_trig_match_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .acc_op(acc_op),
        .acc_priv(acc_priv), .acc_narrow(acc_narrow), .acc_addr(acc_addr),
        .acc_data(acc_data), .dbg_cause(dbg_cause), .raw_hit(raw_hit),
        .hit(hit), .hit_idx(hit_idx), .hit_q(hit_q), .hit_idx_q(hit_idx_q)
    );

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(20 * 200000);
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit [14:0] mk(int act, bit chain, int mode, bit dsel,
                                     bit m, bit s, bit u, bit x, bit st, bit ld);
        bit [14:0] c;
        c = '0;
        c[14:11] = act[3:0];
        c[10] = chain;
        c[9:7] = mode[2:0];
        c[6] = dsel; c[5] = m; c[4] = s; c[3] = u;
        c[2] = x; c[1] = st; c[0] = ld;
        return c;
    endfunction

    function automatic bit fires(int i);
        bit [14:0] c;
        bit [63:0] v, cv, mask, hm;
        bit ok_op, ok_pv;
        int n, half;
        c  = m_ctrl[i];
        cv = m_cmp[i];
        case (acc_op)
            2'd0: ok_op = c[2];
            2'd1: ok_op = c[1];
            2'd2: ok_op = c[0];
            default: ok_op = 1'b0;
        endcase
        case (acc_priv)
            2'd0: ok_pv = c[3];
            2'd1: ok_pv = c[4];
            2'd3: ok_pv = c[5];
            default: ok_pv = 1'b0;
        endcase
        if (!(ok_op && ok_pv)) return 1'b0;
        v = c[6] ? acc_data : acc_addr;
        if (acc_narrow) v[63:32] = '0;
        half = acc_narrow ? 16 : 32;
        hm = cv >> half;
        case (c[9:7])
            3'd0: return v == cv;
            3'd1: begin
                n = 0;
                while (n < 64 && cv[n]) n++;
                mask = (n == 64) ? 64'd0 : ~((64'd1 << n) - 64'd1);
                return (v & mask) == (cv & mask);
            end
            3'd2: return v >= cv;
            3'd3: return v < cv;
            3'd4: return (v & hm) == (cv & hm);
            3'd5: return ((v >> half) & hm) == (cv & hm);
            default: return 1'b0;
        endcase
    endfunction

    // one cycle: inputs already set after a falling edge
    task automatic cycle(string tag);
        bit [3:0] raw;
        bit h, skip;
        int ix;
        #4;
        raw = '0;
        for (int i = 0; i < 4; i++) raw[i] = fires(i);
        if (dbg_cause != 0) raw = '0;
        h = 0; ix = 0; skip = 0;
        for (int i = 0; i < 4; i++) begin
            if (!h) begin
                if (skip) begin
                    if (!m_ctrl[i][10]) skip = 0;
                end else if (raw[i]) begin
                    if (!m_ctrl[i][10]) begin h = 1; ix = i; end
                end else if (m_ctrl[i][10]) begin
                    skip = 1;
                end
            end
        end
        chk(tag, "raw_hit", 64'(raw_hit), 64'(raw));
        chk(tag, "hit", 64'(hit), 64'(h));
        if (h) chk(tag, "hit_idx", 64'(hit_idx), 64'(ix));
        @(posedge clk);
        #1;
        chk("R12", "hit_q", 64'(hit_q), 64'(h));
        if (h) chk("R12", "hit_idx_q", 64'(hit_idx_q), 64'(ix));
        if (cfg_we) begin
            if (cfg_sel) m_cmp[cfg_idx] = cfg_wdata;
            else m_ctrl[cfg_idx] = cfg_wdata[14:0];
        end
        @(negedge clk);
    endtask

    task automatic wr(int idx, bit sel, bit [63:0] val);
        cfg_we = 1; cfg_idx = idx[1:0]; cfg_sel = sel; cfg_wdata = val;
        acc_op = 2'd3;
        cycle("R13");
        cfg_we = 0;
    endtask

    task automatic acc(string tag, int op, int pv, bit [63:0] a, bit [63:0] d, bit nar);
        acc_op = op[1:0]; acc_priv = pv[1:0]; acc_addr = a; acc_data = d;
        acc_narrow = nar;
        cycle(tag);
        acc_op = 2'd3;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 4; i++) begin
            wr(i, 0, 64'd0);
            wr(i, 1, 64'd0);
        end
    endtask

    initial begin
        pool = '{64'h1000, 64'h2000, 64'h4007, 64'hFFFF_FFFF_FFFF_FFFF,
                 64'h0000_FF00_0000_1200, 64'h0000_1234_0000_0000,
                 64'hFFFF_FFFF_8000_1000, 64'h0};
        for (int i = 0; i < 4; i++) begin m_ctrl[i] = '0; m_cmp[i] = '0; end
        @(negedge clk);
        @(negedge clk);
        // R1: registered outputs idle in reset
        chk("R1", "hit_q in reset", 64'(hit_q), 64'd0);
        chk("R1", "hit_idx_q in reset", 64'(hit_idx_q), 64'd0);
        rst_n = 1;
        // R1: nothing fires out of reset for any kind of access
        for (int op = 0; op < 3; op++) acc("R1", op, 3, 64'h0, 64'h0, 0);
        acc("R1", 0, 0, 64'h1000, 64'h0, 0);

        // R7 equality, written through the port (R13)
        wr(0, 0, 64'(mk(0, 0, 0, 0, 1, 0, 0, 1, 0, 0)));
        wr(0, 1, 64'h1000);
        acc("R7", 0, 3, 64'h1000, 64'h0, 0);
        acc("R7", 0, 3, 64'h1001, 64'h0, 0);
        // R4 filtering
        acc("R4", 1, 3, 64'h1000, 64'h0, 0);
        acc("R4", 0, 0, 64'h1000, 64'h0, 0);
        acc("R4", 0, 2, 64'h1000, 64'h0, 0);
        acc("R4", 3, 3, 64'h1000, 64'h0, 0);
        // R13 action bits and reserved modes
        wr(0, 0, 64'(mk(15, 0, 0, 0, 1, 0, 0, 1, 0, 0)));
        acc("R13", 0, 3, 64'h1000, 64'h0, 0);
        wr(0, 0, 64'(mk(0, 0, 6, 0, 1, 1, 1, 1, 1, 1)));
        acc("R9", 0, 3, 64'h1000, 64'h0, 0);
        wr(0, 0, 64'(mk(0, 0, 7, 0, 1, 1, 1, 1, 1, 1)));
        acc("R9", 0, 3, 64'h1000, 64'h0, 0);
        clear_all();

        // R7 GE / LT unsigned
        wr(1, 0, 64'(mk(0, 0, 2, 0, 0, 0, 1, 0, 1, 0)));
        wr(1, 1, 64'h2000);
        wr(2, 0, 64'(mk(0, 0, 3, 0, 0, 0, 1, 0, 1, 0)));
        wr(2, 1, 64'h2000);
        acc("R7", 1, 0, 64'h2000, 64'h0, 0);
        acc("R7", 1, 0, 64'h1FFF, 64'h0, 0);
        acc("R7", 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 0);
        clear_all();

        // R2 priority among identical triggers
        for (int i = 0; i < 4; i++) begin
            wr(i, 0, 64'(mk(0, 0, 0, 0, 1, 1, 1, 1, 1, 1)));
            wr(i, 1, 64'h3000);
        end
        acc("R2", 2, 1, 64'h3000, 64'h0, 0);
        wr(0, 0, 64'd0);
        acc("R2", 2, 1, 64'h3000, 64'h0, 0);
        wr(1, 1, 64'h5);
        acc("R2", 2, 1, 64'h3000, 64'h0, 0);
        // R3 halted
        dbg_cause = 3'd3;
        acc("R3", 2, 1, 64'h3000, 64'h0, 0);
        dbg_cause = 3'd0;
        clear_all();

        // R5 operand select
        wr(0, 0, 64'(mk(0, 0, 0, 1, 1, 0, 0, 0, 1, 0)));
        wr(0, 1, 64'hABCD);
        acc("R5", 1, 3, 64'hABCD, 64'h1, 0);
        acc("R5", 1, 3, 64'h1, 64'hABCD, 0);
        // R6 narrow truncation
        wr(1, 0, 64'(mk(0, 0, 0, 0, 1, 0, 0, 1, 0, 0)));
        wr(1, 1, 64'h8000_1000);
        acc("R6", 0, 3, 64'hFFFF_FFFF_8000_1000, 64'h0, 1);
        acc("R6", 0, 3, 64'hFFFF_FFFF_8000_1000, 64'h0, 0);
        clear_all();

        // R8 NAPOT
        wr(0, 0, 64'(mk(0, 0, 1, 0, 1, 0, 0, 0, 0, 1)));
        wr(0, 1, 64'h4007);
        acc("R8", 2, 3, 64'h4000, 64'h0, 0);
        acc("R8", 2, 3, 64'h4007, 64'h0, 0);
        acc("R8", 2, 3, 64'h4008, 64'h0, 0);
        wr(0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        acc("R8", 2, 3, 64'h1234_5678, 64'h0, 0);
        clear_all();

        // R9 masked halves
        wr(0, 0, 64'(mk(0, 0, 4, 0, 1, 0, 0, 0, 0, 1)));
        wr(0, 1, 64'h0000_FF00_0000_1200);
        acc("R9", 2, 3, 64'h1234, 64'h0, 0);
        acc("R9", 2, 3, 64'h1334, 64'h0, 0);
        wr(0, 0, 64'(mk(0, 0, 5, 0, 1, 0, 0, 0, 0, 1)));
        acc("R9", 2, 3, 64'h0000_1234_0000_0000, 64'h0, 0);
        acc("R9", 2, 3, 64'h1234, 64'h0, 0);
        wr(0, 1, 64'h0000_0000_FF00_1200);
        acc("R6", 2, 3, 64'h1234_0000, 64'h0, 1);
        clear_all();

        // R10 chained pair, R11 broken chain
        wr(0, 0, 64'(mk(0, 1, 0, 0, 1, 0, 0, 1, 0, 0)));
        wr(0, 1, 64'hA000);
        wr(1, 0, 64'(mk(0, 0, 0, 1, 1, 0, 0, 1, 0, 0)));
        wr(1, 1, 64'hB0);
        acc("R10", 0, 3, 64'hA000, 64'hB0, 0);
        acc("R10", 0, 3, 64'hA000, 64'hB1, 0);
        wr(2, 0, 64'(mk(0, 0, 0, 1, 1, 0, 0, 1, 0, 0)));
        wr(2, 1, 64'hB0);
        acc("R11", 0, 3, 64'hA004, 64'hB0, 0);
        acc("R10", 0, 3, 64'hA000, 64'hB0, 0);
        dbg_cause = 3'd1;
        acc("R3", 0, 3, 64'hA000, 64'hB0, 0);
        dbg_cause = 3'd0;
        clear_all();

        // mixed stimulus against the model
        for (int k = 0; k < 600; k++) begin
            int r;
            r = int'($urandom % 8);
            if (r == 0) begin
                bit [63:0] w;
                w = 64'($urandom);
                w[10] = ($urandom % 3 == 0);
                wr(int'($urandom % 4), 0, w);
            end else if (r == 1) begin
                wr(int'($urandom % 4), 1, pool[$urandom % 8]);
            end else begin
                dbg_cause = ($urandom % 10 == 0) ? 3'(1 + $urandom % 7) : 3'd0;
                acc("R2", int'($urandom % 4), int'($urandom % 4),
                    pool[$urandom % 8] + 64'($urandom % 3),
                    pool[$urandom % 8], 1'($urandom % 2));
                dbg_cause = 3'd0;
            end
        end

        summary();
        $finish;
    end

endmodule